// File: doc/BRIEF.md
# Soft-Decision Convolutional Decoder (64-state, register exchange)

This block decodes a rate-1/2 convolutional code with constraint length 7. Each clock cycle in which `in_valid` is high it accepts one pair of 3-bit soft code symbols. In the same cycle, 64 add-compare-select units update every state metric in parallel. Each state's survivor register then takes a shifted copy of the survivor of the predecessor that won. After a fixed decoding depth of 42 symbol pairs, the block returns one hard decoded bit per accepted pair.

The state metrics are 9-bit values that wrap around. Two candidates are compared by the sign of their wrapped difference, so the metrics never need to be rescaled. After reset, state 0 starts at metric 0 and every other state starts at a penalty of 128, which makes decoding begin from the all-zero encoder state.

A small control FSM has two states. `ST_FILL` covers the period while the survivor registers are still filling. It moves to `ST_RUN` on the 42nd accepted pair (transition *fill_done*). `ST_RUN` then holds until reset (transition *hold*). Outputs are enabled from that 42nd pair onward.

Top module: `vit_decoder`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is low. State 0's metric resets to 0 and all other metrics reset to 128, so the first decoded bits assume the encoder started in the zero state.
- R2: A cycle with `in_valid` low is ignored. The soft values on the inputs are not used, `out_valid` is low in the following cycle, and metrics, survivors and `out_bit` hold.
- R3: Each accepted pair, from the 42nd on, gives exactly one `out_valid` pulse. The pulse appears in the cycle that follows the clock edge that accepted the pair.
- R4: The first decoded bit appears with the 42nd accepted pair. Bits come out in input order: bit i appears with pair i+41.
- R5: The code taps are 133 and 171 octal. Window bit 6 holds the newest input bit and bit 0 holds the oldest. The 133 parity is carried on `in_sym0` and the 171 parity on `in_sym1`. Soft value 0 means a confident 0 and 7 means a confident 1. An error-free stream decodes exactly.
- R6: A branch metric is the sum, over both symbols, of the distance from 0 (expected 0) or from 7 (expected 1), giving a range of 0 to 14. Isolated fully inverted symbols, at most one in every 25 pairs, are corrected.
- R7: Metrics are 9 bits and wrap freely. The winner is chosen by the sign of the wrapped difference of the candidates, and a tie goes to the predecessor whose dropped bit is 0. The wrapped spread between any two metrics stays at or below 212. A long stream whose symbols are all weakened toward mid-scale, which forces many wraps, still decodes exactly.
- R8: The control FSM stays in `ST_FILL` until 42 pairs have been accepted. It then stays in `ST_RUN` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Symbol pair present this cycle |
| in_sym0 | input | 3 | Soft value of the 133-octal code bit |
| in_sym1 | input | 3 | Soft value of the 171-octal code bit |
| out_valid | output | 1 | Decoded bit present |
| out_bit | output | 1 | Decoded bit |

## Verification
Every decoded result is registered once: it shows on the ports just after the clock edge that accepts its pair, and it carries the bit of the pair sent 41 pairs earlier. The driver changes inputs on falling edges and pushes each transmitted bit into a queue. The monitor samples 1 ns after each rising edge. At that point the `in_valid` just consumed is still on the pins, so the monitor can predict `out_valid` for that same sample. Whenever `out_valid` is high it compares `out_bit` with the head of the queue. At the end of each phase the bench confirms that the first output arrived when the 42nd pair was sent and that exactly 41 bits remain in the queue.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int K     = 7;
    localparam int NS    = 1 << (K - 1);
    localparam int SW    = 3;
    localparam int BMW   = SW + 1;
    localparam logic [K-1:0] TAP_A = 7'o133;
    localparam logic [K-1:0] TAP_B = 7'o171;
    localparam logic [SW-1:0] SMAX = SW'((1 << SW) - 1);

    typedef enum logic {ST_FILL, ST_RUN} ctl_state_t;

    // code pair for a 7-bit window, newest bit at position K-1
    function automatic logic [1:0] code_pair(input logic [K-1:0] w);
        return {^(w & TAP_A), ^(w & TAP_B)};
    endfunction

    function automatic logic [BMW-1:0] branch_metric(input logic [SW-1:0] s0,
                                                     input logic [SW-1:0] s1,
                                                     input logic [1:0]    expect_bits);
        logic [SW-1:0] d0, d1;
        d0 = expect_bits[1] ? (SMAX - s0) : s0;
        d1 = expect_bits[0] ? (SMAX - s1) : s1;
        return {1'b0, d0} + {1'b0, d1};
    endfunction
endpackage

// File: rtl/vit_acs.sv
module vit_acs
    import vit_pkg::*;
#(
    parameter int ST = 0,
    parameter int MW = 9
) (
    input  logic [SW-1:0] sym0,
    input  logic [SW-1:0] sym1,
    input  logic [MW-1:0] pm_lo,
    input  logic [MW-1:0] pm_hi,
    output logic [MW-1:0] pm_out,
    output logic          pick_hi
);
    localparam logic [K-2:0] S6 = (K-1)'(ST);
    localparam logic [K-1:0] W_LO = {S6, 1'b0};
    localparam logic [K-1:0] W_HI = {S6, 1'b1};
    localparam logic [1:0] C_LO = code_pair(W_LO);
    localparam logic [1:0] C_HI = code_pair(W_HI);

    logic [MW-1:0] cand_lo, cand_hi, diff;

    always_comb begin
        cand_lo = pm_lo + MW'(branch_metric(sym0, sym1, C_LO));
        cand_hi = pm_hi + MW'(branch_metric(sym0, sym1, C_HI));
        diff    = cand_hi - cand_lo;
        pick_hi = diff[MW-1];
        pm_out  = pick_hi ? cand_hi : cand_lo;
    end
endmodule

// File: rtl/vit_ctrl.sv
module vit_ctrl
    import vit_pkg::*;
#(
    parameter int DEPTH = 42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic emit
);
    localparam int CW = $clog2(DEPTH);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    ctl_state_t state, state_nx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (in_valid && state == ST_FILL && cnt != LAST) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: if (in_valid && cnt == LAST) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        emit = 1'b0;
        unique case (state)
            ST_FILL: emit = in_valid && (cnt == LAST);
            ST_RUN:  emit = in_valid;
        endcase
    end

    p_run_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN |=> state == ST_RUN);
endmodule

// File: rtl/vit_decoder.sv
module vit_decoder
    import vit_pkg::*;
#(
    parameter int MW    = 9,
    parameter int DEPTH = 42
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [SW-1:0] in_sym0,
    input  logic [SW-1:0] in_sym1,
    output logic          out_valid,
    output logic          out_bit
);
    localparam logic [MW-1:0] PENALTY = MW'(1 << (MW - 2));
    localparam int SPREAD_MAX = (1 << (MW - 2)) + 2 * int'(SMAX) * (K - 1);

    logic [MW-1:0]    pm     [NS];
    logic [MW-1:0]    pm_nx  [NS];
    logic             pick   [NS];
    logic [DEPTH-1:0] surv   [NS];
    logic             emit;

    for (genvar n = 0; n < NS; n++) begin : g_acs
        localparam int PL = (2 * n) % NS;
        vit_acs #(.ST(n), .MW(MW)) u_acs (
            .sym0    (in_sym0),
            .sym1    (in_sym1),
            .pm_lo   (pm[PL]),
            .pm_hi   (pm[PL + 1]),
            .pm_out  (pm_nx[n]),
            .pick_hi (pick[n])
        );
    end

    vit_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .emit     (emit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NS; n++) begin
                pm[n]   <= (n == 0) ? '0 : PENALTY;
                surv[n] <= '0;
            end
        end else if (in_valid) begin
            for (int n = 0; n < NS; n++) begin
                pm[n]   <= pm_nx[n];
                surv[n] <= {pick[n] ? surv[(2 * n) % NS + 1][DEPTH-2:0]
                                    : surv[(2 * n) % NS][DEPTH-2:0],
                            n >= NS / 2};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= emit;
            if (emit) out_bit <= pick[0] ? surv[1][DEPTH-2] : surv[0][DEPTH-2];
        end
    end

    logic [MW-1:0] sp_diff, sp_mag;
    always_comb begin
        sp_diff = pm[0] - pm[NS-1];
        sp_mag  = sp_diff[MW-1] ? (~sp_diff + 1'b1) : sp_diff;
    end

    p_spread_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sp_mag) <= SPREAD_MAX);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pm[0]) && $stable(surv[0]) && $stable(out_bit)));
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid));
endmodule

// File: tb/sim_vit_decoder.sv
`timescale 1ns/1ps
module sim_vit_decoder;
    localparam logic [6:0] GA = 7'o133;
    localparam logic [6:0] GB = 7'o171;
    localparam int LAT = 42;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] in_sym0 = '0;
    logic [2:0] in_sym1 = '0;
    logic out_valid, out_bit;

    always #2.5 clk = ~clk;

    vit_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_sym0(in_sym0), .in_sym1(in_sym1),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    int checks = 0;
    int errors = 0;
    int sym_sent = 0;
    int first_at = -1;
    bit done = 0;
    bit exp_q[$];
    logic [5:0] enc = '0;
    string cur_req = "R5";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.delete();
        enc = '0;
        sym_sent = 0;
        first_at = -1;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    endtask

    function automatic logic [2:0] shape(input bit c, input int mode);
        if (mode == 1) return c ? 3'($urandom_range(6, 4)) : 3'($urandom_range(3, 1));
        return c ? 3'd7 : 3'd0;
    endfunction

    // mode 0 clean, 1 weakened, 2 first symbol inverted
    task automatic send_bit(input bit b, input int mode);
        logic [6:0] w;
        bit c0, c1;
        logic [2:0] s0, s1;
        w  = {b, enc};
        c0 = ^(w & GA);
        c1 = ^(w & GB);
        enc = w[6:1];
        s0 = shape(c0, mode);
        s1 = shape(c1, mode);
        if (mode == 2) s0 = 3'd7 - s0;
        @(negedge clk);
        exp_q.push_back(b);
        sym_sent++;
        in_valid = 1'b1;
        in_sym0  = s0;
        in_sym1  = s1;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sym0  = 3'($urandom_range(7, 0));
        in_sym1  = 3'($urandom_range(7, 0));
    endtask

    task automatic end_phase();
        idle_cycle();
        repeat (2) @(negedge clk);
        check(first_at == LAT, "R4", first_at, LAT);
        check(exp_q.size() == LAT - 1, "R3", exp_q.size(), LAT - 1);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            bit want;
            want = in_valid && (sym_sent >= LAT);
            check(out_valid == want, in_valid ? "R3 R8" : "R2", int'(out_valid), int'(want));
            if (out_valid) begin
                if (first_at < 0) first_at = sym_sent;
                if (exp_q.size() == 0) check(1'b0, "R4", 1, 0);
                else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(out_bit == e, cur_req, int'(out_bit), int'(e));
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R5: clean random stream
        do_reset();
        cur_req = "R5";
        for (int i = 0; i < 150; i++) send_bit(1'($urandom_range(1, 0)), 0);
        for (int i = 0; i < 48; i++) send_bit(1'b0, 0);
        end_phase();

        // R2: idle gaps carrying garbage symbols
        do_reset();
        cur_req = "R2";
        for (int i = 0; i < 200; i++) begin
            send_bit(1'($urandom_range(1, 0)), 0);
            if ($urandom_range(2, 0) == 0) begin
                idle_cycle();
                idle_cycle();
            end
        end
        for (int i = 0; i < 48; i++) send_bit(1'b0, 0);
        end_phase();

        // R6: isolated inverted symbols
        do_reset();
        cur_req = "R6";
        for (int i = 0; i < 400; i++)
            send_bit(1'($urandom_range(1, 0)), (i % 25 == 12) ? 2 : 0);
        for (int i = 0; i < 48; i++) send_bit(1'b0, 0);
        end_phase();

        // R7: all symbols weakened, metrics wrap many times
        do_reset();
        cur_req = "R7";
        for (int i = 0; i < 1500; i++) send_bit(1'($urandom_range(1, 0)), 1);
        for (int i = 0; i < 48; i++) send_bit(1'b0, 1);
        end_phase();

        // R1: reset mid-stream, then clean restart from zero state
        for (int i = 0; i < 20; i++) send_bit(1'($urandom_range(1, 0)), 0);
        do_reset();
        cur_req = "R1";
        for (int i = 0; i < 60; i++) send_bit(1'b1, 0);
        for (int i = 0; i < 48; i++) send_bit(1'b0, 0);
        end_phase();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule